// File: doc/BRIEF.md
# Register Rename Status Table

This block is the register side of a dynamically scheduled floating-point unit. It holds a small set of architectural registers, and each register carries a producer tag. The tag names the execution station that will deliver the register's next value. A tag of zero means nothing is in flight for that register, so the stored value is current.

An issue transaction does three things at once. It reads two source registers. For each source the block hands back either a value with a zero tag, or a nonzero producer tag with the value forced to zero. If the instruction writes a register, the block also records the issuing station's tag against that destination.

A result broadcast carries a station tag and a data word. It deposits the word into every register still waiting on that tag and clears their tags. Because each rename overwrites the stored tag, a later writer silently displaces an earlier one. The displaced producer's broadcast then finds no match, so only the newest writer updates the architectural value.

The issue port follows valid/ready rules. A transfer happens on any clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is low only during reset: the table never applies back-pressure, because a rename is a single-cycle write. The source outputs are combinational and reflect the current indices even when `iss_valid` is low. The broadcast input cannot be stalled and is qualified only by `bc_valid`.

Top module: `rename_status_table`

## Requirements
- R1: A synchronous active-high reset clears every producer tag to 0 and loads register i with INIT_BASE + i (default INIT_BASE = 0x100).
- R2: A source whose register tag is 0 returns the stored register value with tag 0.
- R3: A source whose register tag is nonzero returns that tag, with the value output forced to 0.
- R4: An accepted issue with `iss_dst_en` high writes `iss_dst_tag` into the destination's tag on that clock edge. Source reads in the same issue see the state from before that rename.
- R5: A broadcast (`bc_valid` high, `bc_tag` nonzero) writes `bc_data` into every register whose tag equals `bc_tag`, and clears those tags to 0.
- R6: A broadcast whose tag matches no register, or one presented with `bc_valid` low, changes no register.
- R7: A second rename of a register supersedes the first. A later broadcast of the first tag leaves the register's tag unchanged.
- R8: When a broadcast is presented in the same cycle as a source read and the broadcast tag equals the source register's tag, the source returns `bc_data` with tag 0.
- R9: When the same register is both renamed and matched by a broadcast in one cycle, the new rename tag is kept.
- R10: With `iss_valid` low, no rename happens. `iss_ready` is high on every cycle outside reset and low during reset.
- R11: An accepted issue with `iss_dst_en` low renames no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | Issue accepted when high |
| iss_src1 | input | IDX_W | First source register index |
| iss_src2 | input | IDX_W | Second source register index |
| iss_dst_en | input | 1 | Issue writes a destination register |
| iss_dst | input | IDX_W | Destination register index |
| iss_dst_tag | input | TAG_W | Tag of the issuing station (nonzero) |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the station that produced the result |
| bc_data | input | DATA_W | Broadcast result word |
| src1_val | output | DATA_W | First source value (0 while pending) |
| src1_tag | output | TAG_W | First source producer tag (0 when value ready) |
| src2_val | output | DATA_W | Second source value (0 while pending) |
| src2_tag | output | TAG_W | Second source producer tag (0 when value ready) |

## Verification
Some properties are checked on every cycle:
- A pending source always shows a zero value.
- `iss_ready` tracks reset.
- An accepted rename lands its tag in the destination on the next edge.
- A matching broadcast tag never appears on a source output, because the bypass must have resolved it.
- No register tag moves in a cycle with neither a rename nor a broadcast.
- Every tag is zero right after reset.

The bench scenarios are needed for the value-level behaviour. That covers a superseded producer being locked out, a broadcast reaching several waiting registers at once, and the rename-over-clear priority when both hit one register. It also covers issue reads that see the state from before their own rename, and the ignored cases (`iss_valid` low, `iss_dst_en` low, a non-matching tag). Each of these is observed later through ordinary source reads.

// File: rtl/rename_tbl_pkg.sv
package rename_tbl_pkg;

  localparam int unsigned DEF_NUM_REGS  = 8;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_NUM_PROD  = 11;
  localparam int unsigned DEF_INIT_BASE = 256;

  // Next-state choice for a slot's producer tag
  typedef enum logic [1:0] {
    TAG_KEEP   = 2'd0,
    TAG_CLEAR  = 2'd1,
    TAG_RENAME = 2'd2
  } tag_sel_e;

endpackage

// File: rtl/rename_tbl_slot.sv
module rename_tbl_slot
  import rename_tbl_pkg::*;
#(
  parameter int unsigned          DATA_W   = DEF_DATA_W,
  parameter int unsigned          TAG_W    = 4,
  parameter logic [DATA_W-1:0]    INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              ren_hit,
  input  logic [TAG_W-1:0]  ren_tag,
  output logic [DATA_W-1:0] val_q,
  output logic [TAG_W-1:0]  tag_q
);

  logic     bc_match;
  tag_sel_e tag_sel;

  assign bc_match = bc_valid && (tag_q != '0) && (tag_q == bc_tag);

  // A rename outranks the clear that a matching broadcast would cause
  always_comb begin
    if (ren_hit)       tag_sel = TAG_RENAME;
    else if (bc_match) tag_sel = TAG_CLEAR;
    else               tag_sel = TAG_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= INIT_VAL;
      tag_q <= '0;
    end else begin
      if (bc_match) val_q <= bc_data;
      unique case (tag_sel)
        TAG_RENAME: tag_q <= ren_tag;
        TAG_CLEAR:  tag_q <= '0;
        default:    tag_q <= tag_q;
      endcase
    end
  end

endmodule

// File: rtl/rename_tbl_read.sv
module rename_tbl_read #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAG_W    = 4,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [IDX_W-1:0]                idx,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] vals,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  tags,
  input  logic                            bc_valid,
  input  logic [TAG_W-1:0]                bc_tag,
  input  logic [DATA_W-1:0]               bc_data,
  output logic [DATA_W-1:0]               out_val,
  output logic [TAG_W-1:0]                out_tag
);

  logic [DATA_W-1:0] raw_val;
  logic [TAG_W-1:0]  raw_tag;
  logic              bypass;

  assign raw_val = vals[idx];
  assign raw_tag = tags[idx];
  assign bypass  = bc_valid && (raw_tag != '0) && (raw_tag == bc_tag);

  always_comb begin
    if (bypass) begin
      out_val = bc_data;
      out_tag = '0;
    end else if (raw_tag != '0) begin
      out_val = '0;
      out_tag = raw_tag;
    end else begin
      out_val = raw_val;
      out_tag = '0;
    end
  end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rename_tbl_pkg::*;
#(
  parameter int unsigned NUM_REGS  = DEF_NUM_REGS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NUM_PROD  = DEF_NUM_PROD,
  parameter int unsigned INIT_BASE = DEF_INIT_BASE,
  localparam int unsigned TAG_W    = $clog2(NUM_PROD + 1),
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [IDX_W-1:0]  iss_src1,
  input  logic [IDX_W-1:0]  iss_src2,
  input  logic              iss_dst_en,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_dst_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic [DATA_W-1:0] src1_val,
  output logic [TAG_W-1:0]  src1_tag,
  output logic [DATA_W-1:0] src2_val,
  output logic [TAG_W-1:0]  src2_tag
);

  logic [NUM_REGS-1:0][DATA_W-1:0] reg_val;
  logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tag;
  logic [NUM_REGS-1:0]             ren_hit;
  logic                            iss_fire;

  assign iss_ready = ~rst;
  assign iss_fire  = iss_valid && iss_ready && iss_dst_en;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slot
    localparam logic [DATA_W-1:0] SLOT_INIT = DATA_W'(INIT_BASE + gi);

    assign ren_hit[gi] = iss_fire && (iss_dst == IDX_W'(gi));

    rename_tbl_slot #(
      .DATA_W   (DATA_W),
      .TAG_W    (TAG_W),
      .INIT_VAL (SLOT_INIT)
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .ren_hit  (ren_hit[gi]),
      .ren_tag  (iss_dst_tag),
      .val_q    (reg_val[gi]),
      .tag_q    (reg_tag[gi])
    );
  end

  rename_tbl_read #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W)
  ) u_rd1 (
    .idx      (iss_src1),
    .vals     (reg_val),
    .tags     (reg_tag),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_data  (bc_data),
    .out_val  (src1_val),
    .out_tag  (src1_tag)
  );

  rename_tbl_read #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W)
  ) u_rd2 (
    .idx      (iss_src2),
    .vals     (reg_val),
    .tags     (reg_tag),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_data  (bc_data),
    .out_val  (src2_val),
    .out_tag  (src2_tag)
  );

endmodule

// File: rtl/rename_status_table_chk.sv
module rename_status_table_chk #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned IDX_W    = 3
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            iss_valid,
  input logic                            iss_ready,
  input logic                            iss_dst_en,
  input logic [IDX_W-1:0]                iss_dst,
  input logic [TAG_W-1:0]                iss_dst_tag,
  input logic                            bc_valid,
  input logic [TAG_W-1:0]                bc_tag,
  input logic [DATA_W-1:0]               src1_val,
  input logic [TAG_W-1:0]                src1_tag,
  input logic [DATA_W-1:0]               src2_val,
  input logic [TAG_W-1:0]                src2_tag,
  input logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tag
);

  // R1
  reset_clears_tags_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_tag == '0));

  // R3
  pending_src1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (src1_tag != '0) |-> (src1_val == '0));

  // R3
  pending_src2_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (src2_tag != '0) |-> (src2_val == '0));

  // R4
  rename_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready && iss_dst_en) |=> (reg_tag[$past(iss_dst)] == $past(iss_dst_tag)));

  // R6
  quiet_cycle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!(iss_valid && iss_ready && iss_dst_en) && !bc_valid) |=> $stable(reg_tag));

  // R8
  bypass_src1_chk: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_tag != '0) |-> (src1_tag != bc_tag));

  // R8
  bypass_src2_chk: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_tag != '0) |-> (src2_tag != bc_tag));

  // R10
  ready_outside_reset_chk: assert property (@(posedge clk)
    iss_ready == !rst);

endmodule

bind rename_status_table rename_status_table_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .TAG_W    (TAG_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .iss_dst_en  (iss_dst_en),
  .iss_dst     (iss_dst),
  .iss_dst_tag (iss_dst_tag),
  .bc_valid    (bc_valid),
  .bc_tag      (bc_tag),
  .src1_val    (src1_val),
  .src1_tag    (src1_tag),
  .src2_val    (src2_val),
  .src2_tag    (src2_tag),
  .reg_tag     (reg_tag)
);

// File: tb/rename_status_table_tb.sv
module rename_status_table_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 8;
  localparam int INIT_BASE  = 256;

  typedef struct packed {
    logic        iv;
    logic [2:0]  s1;
    logic [2:0]  s2;
    logic        de;
    logic [2:0]  d;
    logic [3:0]  dt;
    logic        bv;
    logic [3:0]  bt;
    logic [31:0] bd;
    logic [3:0]  e1t;
    logic [31:0] e1v;
    logic [3:0]  e2t;
    logic [31:0] e2v;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,3'd1,3'd2,1'b0,3'd0,4'd0,1'b0,4'd0,32'h0,  4'd0,32'h101,4'd0,32'h102}, // 0 R2
    '{1'b1,3'd3,3'd4,1'b1,3'd1,4'd5,1'b0,4'd0,32'h0,  4'd0,32'h103,4'd0,32'h104}, // 1 R2 R4
    '{1'b1,3'd1,3'd2,1'b1,3'd2,4'd7,1'b0,4'd0,32'h0,  4'd5,32'h0,  4'd0,32'h102}, // 2 R3 R4
    '{1'b0,3'd1,3'd2,1'b1,3'd3,4'd9,1'b1,4'd3,32'hAA, 4'd5,32'h0,  4'd7,32'h0  }, // 3 R10 R6
    '{1'b1,3'd3,3'd1,1'b0,3'd3,4'd9,1'b0,4'd5,32'hBB, 4'd0,32'h103,4'd5,32'h0  }, // 4 R10 R6 R11
    '{1'b1,3'd3,3'd1,1'b0,3'd0,4'd0,1'b1,4'd5,32'h55, 4'd0,32'h103,4'd0,32'h55 }, // 5 R11 R8
    '{1'b1,3'd1,3'd2,1'b1,3'd1,4'd2,1'b0,4'd0,32'h0,  4'd0,32'h55, 4'd7,32'h0  }, // 6 R5
    '{1'b1,3'd1,3'd0,1'b1,3'd1,4'd4,1'b0,4'd0,32'h0,  4'd2,32'h0,  4'd0,32'h100}, // 7 R7
    '{1'b1,3'd1,3'd2,1'b0,3'd0,4'd0,1'b1,4'd2,32'h22, 4'd4,32'h0,  4'd7,32'h0  }, // 8 R7
    '{1'b1,3'd1,3'd4,1'b1,3'd1,4'd6,1'b1,4'd4,32'h44, 4'd0,32'h44, 4'd0,32'h104}, // 9 R8 R9
    '{1'b1,3'd1,3'd2,1'b0,3'd0,4'd0,1'b1,4'd7,32'h77, 4'd6,32'h0,  4'd0,32'h77 }, // 10 R9 R8
    '{1'b1,3'd2,3'd1,1'b1,3'd5,4'd6,1'b0,4'd0,32'h0,  4'd0,32'h77, 4'd6,32'h0  }, // 11 R5
    '{1'b1,3'd1,3'd5,1'b0,3'd0,4'd0,1'b1,4'd6,32'h66, 4'd0,32'h66, 4'd0,32'h66 }, // 12 R8
    '{1'b1,3'd1,3'd5,1'b0,3'd0,4'd0,1'b0,4'd0,32'h0,  4'd0,32'h66, 4'd0,32'h66 }, // 13 R5
    '{1'b1,3'd6,3'd6,1'b1,3'd6,4'd3,1'b0,4'd0,32'h0,  4'd0,32'h106,4'd0,32'h106}, // 14 R4
    '{1'b1,3'd6,3'd0,1'b0,3'd0,4'd0,1'b0,4'd0,32'h0,  4'd3,32'h0,  4'd0,32'h100}  // 15 R4
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid;
  logic        iss_ready;
  logic [2:0]  iss_src1, iss_src2, iss_dst;
  logic        iss_dst_en;
  logic [3:0]  iss_dst_tag;
  logic        bc_valid;
  logic [3:0]  bc_tag;
  logic [31:0] bc_data;
  logic [31:0] src1_val, src2_val;
  logic [3:0]  src1_tag, src2_tag;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_status_table u_dut (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_dst_tag(iss_dst_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .src1_val(src1_val), .src1_tag(src1_tag),
    .src2_val(src2_val), .src2_tag(src2_tag)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got tag=%0d val=%h, expected tag=%0d val=%h",
               req, act[35:32], act[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic idle();
    iss_valid = 1'b0; iss_src1 = '0; iss_src2 = '0;
    iss_dst_en = 1'b0; iss_dst = '0; iss_dst_tag = '0;
    bc_valid = 1'b0; bc_tag = '0; bc_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle();
    repeat (2) @(negedge clk);
    #1;
    n_checks++;
    if (iss_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: iss_ready=%b during reset, expected 0", iss_ready);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle();
    do_reset();

    // R1: every register holds its init value with no producer
    for (int r = 0; r < NREG; r++) begin
      iss_src1 = 3'(r);
      iss_src2 = 3'(NREG - 1 - r);
      #1;
      chk("R1 src1", {src1_tag, src1_val}, {4'd0, 32'(INIT_BASE + r)});
      chk("R1 src2", {src2_tag, src2_val}, {4'd0, 32'(INIT_BASE + NREG - 1 - r)});
    end

    // R10: ready after reset
    #1;
    n_checks++;
    if (iss_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: iss_ready=%b after reset, expected 1", iss_ready);
    end

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      iss_valid   = VEC[i].iv;
      iss_src1    = VEC[i].s1;
      iss_src2    = VEC[i].s2;
      iss_dst_en  = VEC[i].de;
      iss_dst     = VEC[i].d;
      iss_dst_tag = VEC[i].dt;
      bc_valid    = VEC[i].bv;
      bc_tag      = VEC[i].bt;
      bc_data     = VEC[i].bd;
      #1;
      chk($sformatf("vec%0d src1", i), {src1_tag, src1_val}, {VEC[i].e1t, VEC[i].e1v});
      chk($sformatf("vec%0d src2", i), {src2_tag, src2_val}, {VEC[i].e2t, VEC[i].e2v});
    end

    // R1: a second reset drops pending tag on r6 and restores r1's value
    do_reset();
    iss_src1 = 3'd6;
    iss_src2 = 3'd1;
    #1;
    chk("R1 rereset r6", {src1_tag, src1_val}, {4'd0, 32'h106});
    chk("R1 rereset r1", {src2_tag, src2_val}, {4'd0, 32'h101});

    // R6: a broadcast of tag 0 does nothing (no register may match it)
    @(negedge clk);
    bc_valid = 1'b1; bc_tag = 4'd0; bc_data = 32'hDEAD;
    @(negedge clk);
    idle();
    iss_src1 = 3'd2;
    iss_src2 = 3'd7;
    #1;
    chk("R6 tag0 bc r2", {src1_tag, src1_val}, {4'd0, 32'h102});
    chk("R6 tag0 bc r7", {src2_tag, src2_val}, {4'd0, 32'h107});

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule